// File: doc/BRIEF.md
# Burst Read Return with Write Forwarding

This block is the read side of a dual-port burst memory. A read request is accepted on a rising clock edge. The block fetches one 72-bit word from a byte-lane array and returns it as four 18-bit beats over the next two clock cycles. Each cycle carries a pair of beats: the beat for the rising edge of the pad clock and the beat for its falling edge. A pad register pair outside this block turns each pair into double-data-rate transfers. Reads can be accepted on every other edge. When they are, the output carries valid beats in every cycle with no gap.

The write side of the same block accepts a write address on one edge. It then collects two beat pairs, each with per-byte enables, on the following two edges and commits the word on the second of those edges. A read to the address of a write that started on the previous edge, or of a write that is committing on the read's own edge, sees that write's data. The data is merged byte by byte: bytes the write enables come from the write buffer, and masked bytes come from the array. The upstream arbiter never issues a read and a write on the same edge.

The output qualifier is high only while beats are valid. The data bus reads as zero whenever the qualifier is low. The qualifier drops at the edge after the last beat pair once no further read is pending.

Top module: `burst_rd_fwd`

## Requirements
- R1: A read accepted on edge E drives `q_oe` high and `q` = word bits [35:0] after edge E+1, and `q` = word bits [71:36] after edge E+2. Beat k of the word occupies bits [18k+17:18k]. Within `q`, bits [17:0] are the rising-edge beat and bits [35:18] are the falling-edge beat.
- R2: A read request on the edge right after an accepted read is ignored. Reads accepted on every other edge keep `q_oe` high without a gap.
- R3: A write accepted on edge E takes beats 0 and 1 from `wr_beats` at E+1 and beats 2 and 3 at E+2, then commits. Enable bit j of the 8-bit word mask (1 = write) covers word bits [9j+8:9j]. `wr_be` bit 0 applies to `wr_beats` bits [8:0], and so on upward. Masked bytes keep their old value.
- R4: A write request on the edge right after an accepted write is ignored. Its address and data are not stored.
- R5: A read accepted on the edge after a write to the same address returns that write's data.
- R6: A read accepted on the same edge as a same-address write's commit returns the new data.
- R7: Forwarded data is merged per byte. Masked bytes of the pending write come from the array contents.
- R8: `q_oe` falls at the edge after the last beat pair when no read follows. `q` is all zero while `q_oe` is low.
- R9: A synchronous reset clears `q_oe`, `q` and both port sequencers, including a burst that is in progress. The array contents are not cleared.
- R10: A read to an address other than the pending write's address returns the array contents without forwarding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel | input | 1 | Read request |
| rd_addr | input | 8 | Read word address |
| wr_sel | input | 1 | Write request |
| wr_addr | input | 8 | Write word address |
| wr_beats | input | 36 | Write beat pair, rising-edge beat in bits [17:0] |
| wr_be | input | 4 | Byte enables for the beat pair, 1 = write |
| q | output | 36 | Read beat pair, rising-edge beat in bits [17:0] |
| q_oe | output | 1 | Output qualifier; high while beats are valid |

## Verification
Two functions can land on the same edge: the array read for a new read, and either the arrival of a pending write's upper beats or that write's commit to the array. The bench places a read one edge after a write to the same address, once with a full mask and once with a partial mask. It also places a read two edges after a write, so that the array read and the commit coincide. Each returned beat pair is judged against a bench model that applies every write in full at the moment it is issued. Any stale byte or wrongly merged byte therefore shows up in the pair where it appears.

// File: rtl/rbf_pkg.sv
package rbf_pkg;
  // sequencer phase shared by both ports: idle, low pair due, high pair due
  typedef enum logic [1:0] {PH_IDLE, PH_LO, PH_HI} ph_e;
endpackage

// File: rtl/rbf_wr_stage.sv
module rbf_wr_stage
  import rbf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BEAT_W = 18,
  parameter int BYTE_W = 9
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wr_sel,
  input  logic [ADDR_W-1:0]                    wr_addr,
  input  logic [2*BEAT_W-1:0]                  wr_beats,
  input  logic [2*(BEAT_W/BYTE_W)-1:0]         wr_be,
  output logic                                 pend,
  output logic [ADDR_W-1:0]                    buf_addr,
  output logic [4*BEAT_W-1:0]                  buf_data,
  output logic [4*(BEAT_W/BYTE_W)-1:0]         buf_be,
  output logic                                 cm_we,
  output logic [ADDR_W-1:0]                    cm_addr,
  output logic [4*BEAT_W-1:0]                  cm_data,
  output logic [4*(BEAT_W/BYTE_W)-1:0]         cm_be
);
  localparam int PAIR_W  = 2 * BEAT_W;
  localparam int PAIR_BE = 2 * (BEAT_W / BYTE_W);
  localparam int WORD_W  = 2 * PAIR_W;
  localparam int WORD_BE = 2 * PAIR_BE;

  ph_e  ph;
  logic accept;

  assign accept = wr_sel && (ph != PH_LO);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      buf_addr <= '0;
      buf_data <= '0;
      buf_be   <= '0;
    end else begin
      if (ph == PH_LO) begin
        buf_data[PAIR_W-1:0]  <= wr_beats;
        buf_be[PAIR_BE-1:0]   <= wr_be;
      end
      if (ph == PH_HI) begin
        buf_data[WORD_W-1:PAIR_W]   <= wr_beats;
        buf_be[WORD_BE-1:PAIR_BE]   <= wr_be;
      end
      if (accept) begin
        buf_addr <= wr_addr;
        ph       <= PH_LO;
      end else begin
        ph <= (ph == PH_LO) ? PH_HI : PH_IDLE;
      end
    end
  end

  assign pend    = (ph != PH_IDLE);
  assign cm_we   = (ph == PH_HI);
  assign cm_addr = buf_addr;
  assign cm_data = {wr_beats, buf_data[PAIR_W-1:0]};
  assign cm_be   = {wr_be, buf_be[PAIR_BE-1:0]};

  // R4: a request while the low pair is due cannot restart the burst
  a_r4_busy_ignored: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_LO) |=> (ph == PH_HI));
  a_r4_addr_held: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_LO) |=> $stable(buf_addr));
endmodule

// File: rtl/rbf_lane_ram.sv
module rbf_lane_ram #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 9,
  parameter int LANES  = 8
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [LANES*BYTE_W-1:0]   wdata,
  input  logic [LANES-1:0]          wbe,
  input  logic                      re,
  input  logic [ADDR_W-1:0]         raddr,
  output logic [LANES*BYTE_W-1:0]   rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] rq;
    always_ff @(posedge clk) begin
      if (we && wbe[l]) mem[waddr] <= wdata[l*BYTE_W +: BYTE_W];
      if (re) rq <= mem[raddr];
    end
    assign rdata[l*BYTE_W +: BYTE_W] = rq;
  end
endmodule

// File: rtl/rbf_rd_seq.sv
module rbf_rd_seq
  import rbf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BEAT_W = 18,
  parameter int BYTE_W = 9
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rd_sel,
  input  logic [ADDR_W-1:0]             rd_addr,
  input  logic                          wr_pend,
  input  logic [ADDR_W-1:0]             buf_addr,
  input  logic [4*BEAT_W-1:0]           buf_data,
  input  logic [4*(BEAT_W/BYTE_W)-1:0]  buf_be,
  input  logic [4*BEAT_W-1:0]           arr_data,
  output logic                          arr_re,
  output logic [2*BEAT_W-1:0]           q,
  output logic                          q_oe
);
  localparam int PAIR_W  = 2 * BEAT_W;
  localparam int WORD_W  = 2 * PAIR_W;
  localparam int WORD_BE = 4 * (BEAT_W / BYTE_W);

  ph_e               ph;
  logic              accept;
  logic              hit_q;
  logic [WORD_W-1:0] mw;
  logic [PAIR_W-1:0] pair;

  assign accept = rd_sel && (ph != PH_LO);
  assign arr_re = accept;

  for (genvar j = 0; j < WORD_BE; j++) begin : g_merge
    assign mw[j*BYTE_W +: BYTE_W] = (hit_q && buf_be[j]) ?
      buf_data[j*BYTE_W +: BYTE_W] : arr_data[j*BYTE_W +: BYTE_W];
  end

  assign pair = (ph == PH_HI) ? mw[WORD_W-1:PAIR_W] : mw[PAIR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_IDLE;
      hit_q <= 1'b0;
      q     <= '0;
      q_oe  <= 1'b0;
    end else begin
      if (ph != PH_IDLE) begin
        q    <= pair;
        q_oe <= 1'b1;
      end else begin
        q    <= '0;
        q_oe <= 1'b0;
      end
      if (accept) begin
        ph    <= PH_LO;
        hit_q <= wr_pend && (buf_addr == rd_addr);
      end else begin
        ph <= (ph == PH_LO) ? PH_HI : PH_IDLE;
      end
    end
  end

  // R2: no restart while the low pair is due
  a_r2_no_restart: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_LO) |=> (ph == PH_HI));
  // R1: every burst spans two output cycles
  a_r1_two_pairs: assert property (@(posedge clk) disable iff (rst)
    $rose(q_oe) |=> q_oe);
  // R8: qualifier drops once nothing is due
  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_IDLE) |=> !q_oe);
  a_r8_quiet_bus: assert property (@(posedge clk) disable iff (rst)
    !q_oe |-> (q == '0));
endmodule

// File: rtl/burst_rd_fwd.sv
module burst_rd_fwd #(
  parameter int ADDR_W = 8,
  parameter int BEAT_W = 18,
  parameter int BYTE_W = 9
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              rd_sel,
  input  logic [ADDR_W-1:0]                 rd_addr,
  input  logic                              wr_sel,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [2*BEAT_W-1:0]               wr_beats,
  input  logic [2*(BEAT_W/BYTE_W)-1:0]      wr_be,
  output logic [2*BEAT_W-1:0]               q,
  output logic                              q_oe
);
  localparam int WORD_W  = 4 * BEAT_W;
  localparam int WORD_BE = 4 * (BEAT_W / BYTE_W);

  logic                wr_pend, cm_we, arr_re;
  logic [ADDR_W-1:0]   buf_addr, cm_addr;
  logic [WORD_W-1:0]   buf_data, cm_data, arr_data;
  logic [WORD_BE-1:0]  buf_be, cm_be;

  rbf_wr_stage #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .BYTE_W(BYTE_W)) u_wr (
    .clk(clk), .rst(rst), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_beats(wr_beats), .wr_be(wr_be), .pend(wr_pend),
    .buf_addr(buf_addr), .buf_data(buf_data), .buf_be(buf_be),
    .cm_we(cm_we), .cm_addr(cm_addr), .cm_data(cm_data), .cm_be(cm_be));

  rbf_lane_ram #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LANES(WORD_BE)) u_ram (
    .clk(clk), .we(cm_we), .waddr(cm_addr), .wdata(cm_data), .wbe(cm_be),
    .re(arr_re), .raddr(rd_addr), .rdata(arr_data));

  rbf_rd_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .BYTE_W(BYTE_W)) u_rd (
    .clk(clk), .rst(rst), .rd_sel(rd_sel), .rd_addr(rd_addr),
    .wr_pend(wr_pend), .buf_addr(buf_addr), .buf_data(buf_data),
    .buf_be(buf_be), .arr_data(arr_data), .arr_re(arr_re),
    .q(q), .q_oe(q_oe));

  // R3: a commit happens exactly two edges after an issued write
  a_r3_commit_slot: assert property (@(posedge clk) disable iff (rst)
    cm_we |-> $past(wr_sel, 2));
endmodule

// File: tb/burst_rd_fwd_tb.sv
module burst_rd_fwd_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 44;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_sel = 1'b0, wr_sel = 1'b0;
  logic [7:0]  rd_addr = '0, wr_addr = '0;
  logic [35:0] wr_beats = '0;
  logic [3:0]  wr_be = '0;
  logic [35:0] q;
  logic        q_oe;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_rd_fwd u_dut (.clk(clk), .rst(rst), .rd_sel(rd_sel), .rd_addr(rd_addr),
    .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_beats(wr_beats), .wr_be(wr_be),
    .q(q), .q_oe(q_oe));

  // entry: {op[2:0], addr, seed, mask, tag}; op 0 idle, 1 write, 2 read,
  // 3 write that must be ignored, 4 read that must be ignored
  localparam logic [30:0] VEC [NV] = '{
    {3'd1,8'h10,8'h11,8'hFF,4'd3}, {3'd0,8'h00,8'h00,8'h00,4'd8},
    {3'd1,8'h20,8'h22,8'hFF,4'd3}, {3'd0,8'h00,8'h00,8'h00,4'd8},
    {3'd1,8'h30,8'h33,8'hFF,4'd3}, {3'd0,8'h00,8'h00,8'h00,4'd8},
    {3'd1,8'h50,8'h99,8'hFF,4'd3}, {3'd0,8'h00,8'h00,8'h00,4'd8},
    {3'd0,8'h00,8'h00,8'h00,4'd8},
    {3'd2,8'h10,8'h00,8'h00,4'd1},  // R1 plain read
    {3'd0,8'h00,8'h00,8'h00,4'd8},
    {3'd2,8'h20,8'h00,8'h00,4'd2},  // R2 no gap
    {3'd0,8'h00,8'h00,8'h00,4'd8},
    {3'd2,8'h30,8'h00,8'h00,4'd1},
    {3'd4,8'h50,8'h00,8'h00,4'd2},  // R2 ignored read
    {3'd0,8'h00,8'h00,8'h00,4'd8}, {3'd0,8'h00,8'h00,8'h00,4'd8},
    {3'd0,8'h00,8'h00,8'h00,4'd8},
    {3'd1,8'h10,8'h44,8'hFF,4'd5},
    {3'd2,8'h10,8'h00,8'h00,4'd5},  // R5 forward from previous edge
    {3'd1,8'h20,8'h55,8'h0F,4'd7},
    {3'd2,8'h20,8'h00,8'h00,4'd7},  // R7 per-byte merge
    {3'd0,8'h00,8'h00,8'h00,4'd8},
    {3'd1,8'h30,8'h66,8'hA5,4'd7},
    {3'd0,8'h00,8'h00,8'h00,4'd8},
    {3'd2,8'h30,8'h00,8'h00,4'd6},  // R6 read on commit edge
    {3'd0,8'h00,8'h00,8'h00,4'd8}, {3'd0,8'h00,8'h00,8'h00,4'd8},
    {3'd1,8'h40,8'h77,8'hFF,4'd3},
    {3'd3,8'h50,8'h88,8'hFF,4'd4},  // R4 ignored write
    {3'd2,8'h40,8'h00,8'h00,4'd6},
    {3'd0,8'h00,8'h00,8'h00,4'd8},
    {3'd2,8'h50,8'h00,8'h00,4'd4},
    {3'd0,8'h00,8'h00,8'h00,4'd8},
    {3'd1,8'h60,8'h12,8'hFF,4'd3},
    {3'd2,8'h10,8'h00,8'h00,4'd10}, // R10 other address
    {3'd0,8'h00,8'h00,8'h00,4'd8},
    {3'd2,8'h20,8'h00,8'h00,4'd3},  // R3 committed partial write
    {3'd0,8'h00,8'h00,8'h00,4'd8},
    {3'd2,8'h60,8'h00,8'h00,4'd3},
    {3'd0,8'h00,8'h00,8'h00,4'd8}, {3'd0,8'h00,8'h00,8'h00,4'd8},
    {3'd0,8'h00,8'h00,8'h00,4'd8}, {3'd0,8'h00,8'h00,8'h00,4'd8}
  };

  logic [71:0] model [256];
  logic        sv [4];
  logic [35:0] sq [4];
  int          st [4];
  int          wstage = 0;
  logic [71:0] wd = '0;
  logic [7:0]  wm = '0;

  function automatic logic [71:0] pat(input logic [7:0] s);
    logic [71:0] r;
    for (int j = 0; j < 8; j++) r[j*9 +: 9] = {j[0], s + 8'(17*j)};
    return r;
  endfunction

  task automatic clear_slots(input int tag);
    for (int i = 0; i < 4; i++) begin sv[i] = 0; sq[i] = '0; st[i] = tag; end
  endtask

  task automatic check(input int tag, input logic eoe, input logic [35:0] eq);
    checks++;
    if (q_oe !== eoe || q !== eq) begin
      errors++;
      $display("FAIL R%0d: q_oe=%0b q=%h expected q_oe=%0b q=%h", tag, q_oe, q, eoe, eq);
    end
  endtask

  task automatic step(input logic [30:0] e);
    logic [2:0] op;
    logic [7:0] a, seed, m;
    int tag;
    {op, a, seed, m, tag} = {e, 28'd0} >> 28;
    op = e[30:28]; a = e[27:20]; seed = e[19:12]; m = e[11:4]; tag = int'(e[3:0]);
    @(negedge clk);
    check(st[0], sv[0], sv[0] ? sq[0] : 36'd0);
    for (int i = 0; i < 3; i++) begin sv[i] = sv[i+1]; sq[i] = sq[i+1]; st[i] = st[i+1]; end
    sv[3] = 0; sq[3] = '0; st[3] = 8;
    rd_sel = 0; wr_sel = 0; wr_beats = '0; wr_be = '0;
    if (wstage == 1) begin wr_beats = wd[35:0]; wr_be = wm[3:0]; wstage = 2; end
    else if (wstage == 2) begin wr_beats = wd[71:36]; wr_be = wm[7:4]; wstage = 0; end
    case (op)
      3'd1: begin
        wr_sel = 1; wr_addr = a; wd = pat(seed); wm = m; wstage = 1;
        for (int j = 0; j < 8; j++) if (m[j]) model[a][j*9 +: 9] = wd[j*9 +: 9];
      end
      3'd2: begin
        rd_sel = 1; rd_addr = a;
        sv[1] = 1; sq[1] = model[a][35:0];  st[1] = tag;
        sv[2] = 1; sq[2] = model[a][71:36]; st[2] = tag;
      end
      3'd3: begin wr_sel = 1; wr_addr = a; end
      3'd4: begin
        rd_sel = 1; rd_addr = a;
        if (!sv[1]) st[1] = tag;
        if (!sv[2]) st[2] = tag;
      end
      default: ;
    endcase
  endtask

  initial begin
    clear_slots(9);
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check(9, 1'b0, 36'd0);  // R9 reset state
    rst = 0;
    for (int i = 0; i < NV; i++) step(VEC[i]);
    // R9: reset in the middle of a burst silences the bus at once
    step({3'd2, 8'h10, 8'h00, 8'h00, 4'd9});
    @(negedge clk);
    rd_sel = 0; rst = 1;
    @(negedge clk);
    check(9, 1'b0, 36'd0);
    rst = 0;
    clear_slots(9);
    for (int i = 0; i < 3; i++) step({3'd0, 8'h00, 8'h00, 8'h00, 4'd9});
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements): run incomplete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule